// File: doc/BRIEF.md
# General-Purpose Condition Flag Register

This block keeps the eight general-purpose condition flags that a bus-controller sequencer tests alongside eight message-result codes. The two groups are joined into one 16-bit condition code vector. The low byte holds the flags and the high byte passes the result codes of the most recent message straight through. The result codes are produced elsewhere and only enter this block as an input.

Three sources can change the flags: a host write port, the sequencer's flag instruction and the timer-compare result. The host and the sequencer each give a set mask and a clear mask in one operation. For each bit, set alone forces a 1, clear alone forces a 0, both together invert the bit, and neither leaves it unchanged. The timer-compare path can only reach flags 0 and 1, and it writes an explicit value under a two-bit mask. When several sources are active in one cycle, the host is applied first, then the sequencer, then the timer. Every flag change shows on the vector one clock after the write.

Top module: `cond_flag_reg`

## Requirements
- R1: While rst_n is low, all eight flags (cc_vec[7:0]) are 0.
- R2: cc_vec[15:8] always equals msg_cc with no register delay, and cc_vec[7:0] holds the flag state.
- R3: When host_we is high at a clock edge, each flag bit i follows the host masks: host_set[i]=1 with host_clr[i]=0 sets the bit, host_set[i]=0 with host_clr[i]=1 clears it, and both 1 inverts it. The result is visible on cc_vec[i] after that edge.
- R4: When seq_we is high at a clock edge, the sequencer masks seq_set and seq_clr act on the flags with the same set, clear and invert encoding as R3.
- R5: When host and sequencer write in the same cycle, the sequencer masks act on the value the host write produces. For example, a host set followed by a sequencer invert leaves the bit at 0.
- R6: When tmr_we is high, each flag bit i in 0..1 with tmr_mask[i]=1 takes the value tmr_val[i]. This is applied after the host and sequencer updates of the same cycle.
- R7: The timer-compare inputs never change flags 2 to 7.
- R8: A bit whose set and clear masks are both 0 in an active host or sequencer write keeps its value. With no write enable high, all flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_we | input | 1 | Host flag write strobe |
| host_set | input | 8 | Host set mask |
| host_clr | input | 8 | Host clear mask |
| seq_we | input | 1 | Sequencer flag instruction strobe |
| seq_set | input | 8 | Sequencer set mask |
| seq_clr | input | 8 | Sequencer clear mask |
| tmr_we | input | 1 | Timer-compare result strobe |
| tmr_mask | input | 2 | Flags 0 and 1 that the timer writes |
| tmr_val | input | 2 | Values the timer writes to flags 0 and 1 |
| msg_cc | input | 8 | Result codes of the most recent message |
| cc_vec | output | 16 | Condition code vector, read-only |

## Verification
The hardest case to reach from the ports is all three writers acting on the same bit in one cycle, with masks that conflict in each of the four encodings. The ordering only shows in that case. The random phase draws each strobe with high probability and draws masks densely, so triple collisions on flags 0 and 1 occur often. Directed cycles then pin down a host set followed by a sequencer invert, two inverts in a row, and a timer write that overrides both.

// File: rtl/cond_flag_reg.sv
module cond_flag_reg #(
  parameter int GP_W  = 8,
  parameter int MSG_W = 8,
  parameter int TMR_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   host_we,
  input  logic [GP_W-1:0]        host_set,
  input  logic [GP_W-1:0]        host_clr,
  input  logic                   seq_we,
  input  logic [GP_W-1:0]        seq_set,
  input  logic [GP_W-1:0]        seq_clr,
  input  logic                   tmr_we,
  input  logic [TMR_W-1:0]       tmr_mask,
  input  logic [TMR_W-1:0]       tmr_val,
  input  logic [MSG_W-1:0]       msg_cc,
  output logic [MSG_W+GP_W-1:0]  cc_vec
);

  localparam int HI_W = GP_W - TMR_W;

  logic [GP_W-1:0] gp_q, after_host, after_seq, gp_d;
  logic [GP_W-1:0] tmr_mask_w, tmr_val_w;

  function automatic logic [GP_W-1:0] apply_masks(
    input logic [GP_W-1:0] v, input logic [GP_W-1:0] s, input logic [GP_W-1:0] c);
    return ((v | s) & ~c) | (~v & s & c);
  endfunction

  assign tmr_mask_w = {{HI_W{1'b0}}, tmr_mask & {TMR_W{tmr_we}}};
  assign tmr_val_w  = {{HI_W{1'b0}}, tmr_val};

  assign after_host = host_we ? apply_masks(gp_q, host_set, host_clr) : gp_q;
  assign after_seq  = seq_we  ? apply_masks(after_host, seq_set, seq_clr) : after_host;
  assign gp_d       = (after_seq & ~tmr_mask_w) | (tmr_val_w & tmr_mask_w);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) gp_q <= '0;
    else        gp_q <= gp_d;

  assign cc_vec = {msg_cc, gp_q};

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> cc_vec[GP_W-1:0] == '0);  // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !host_we && !seq_we && !tmr_we |=> $stable(cc_vec[GP_W-1:0]));  // R8

  AST_TMR_UPPER_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_we && !host_we && !seq_we |=> $stable(cc_vec[GP_W-1:TMR_W]));  // R7

  AST_SEQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    seq_we && !tmr_we |=> ((cc_vec[GP_W-1:0] & $past(seq_set & ~seq_clr))
                           == $past(seq_set & ~seq_clr)));  // R5

  AST_SEQ_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    seq_we && !tmr_we |=> ((cc_vec[GP_W-1:0] & $past(seq_clr & ~seq_set)) == '0));  // R5

  AST_TMR_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_we |=> ((cc_vec[TMR_W-1:0] & $past(tmr_mask))
                == ($past(tmr_val) & $past(tmr_mask))));  // R6

endmodule

// File: tb/test_cond_flag_reg.sv
module test_cond_flag_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_we = 1'b0, seq_we = 1'b0, tmr_we = 1'b0;
  logic [7:0] host_set = '0, host_clr = '0, seq_set = '0, seq_clr = '0, msg_cc = '0;
  logic [1:0] tmr_mask = '0, tmr_val = '0;
  logic [15:0] cc_vec;
  logic [7:0] exp_gp;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cond_flag_reg i_cond_flag_reg (.*);

  function automatic logic [7:0] f_masks(logic [7:0] v, logic [7:0] s, logic [7:0] c);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      case ({s[i], c[i]})
        2'b10:   r[i] = 1'b1;
        2'b01:   r[i] = 1'b0;
        2'b11:   r[i] = ~v[i];
        default: r[i] = v[i];
      endcase
    return r;
  endfunction

  function automatic logic [7:0] f_next(logic [7:0] v);
    logic [7:0] r = v;
    if (host_we) r = f_masks(r, host_set, host_clr);
    if (seq_we)  r = f_masks(r, seq_set, seq_clr);
    if (tmr_we)
      for (int i = 0; i < 2; i++) if (tmr_mask[i]) r[i] = tmr_val[i];
    return r;
  endfunction

  task automatic check(string req, logic [15:0] exp);
    n_tests++;
    if (cc_vec !== exp) begin
      n_fail++;
      $display("FAIL %s: cc_vec=%h expected %h", req, cc_vec, exp);
    end
  endtask

  task automatic step(string req);
    logic [7:0] nxt = f_next(exp_gp);
    @(posedge clk); #1;
    exp_gp = nxt;
    check(req, {msg_cc, exp_gp});
    @(negedge clk);
  endtask

  task automatic drive(bit hw, logic [7:0] hs, logic [7:0] hc, bit sw, logic [7:0] ss,
                       logic [7:0] sc, bit tw, logic [1:0] tm, logic [1:0] tv);
    host_we = hw; host_set = hs; host_clr = hc;
    seq_we = sw; seq_set = ss; seq_clr = sc;
    tmr_we = tw; tmr_mask = tm; tmr_val = tv;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    exp_gp = '0;
    msg_cc = 8'hA5;
    drive(1, 8'hFF, 8'h00, 1, 8'hFF, 8'h00, 1, 2'b11, 2'b11);
    repeat (3) @(negedge clk);
    check("R1 reset clears flags", {8'hA5, 8'h00});
    rst_n = 1'b1;
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    msg_cc = 8'h3C; #1;
    check("R2 message codes pass through", {8'h3C, exp_gp});

    drive(1, 8'hF0, 8'h00, 0, 0, 0, 0, 0, 0); step("R3 host set");
    drive(1, 8'h00, 8'h30, 0, 0, 0, 0, 0, 0); step("R3 host clear");
    drive(1, 8'h81, 8'h81, 0, 0, 0, 0, 0, 0); step("R3 host invert");
    drive(0, 0, 0, 1, 8'h0C, 8'h00, 0, 0, 0); step("R4 seq set");
    drive(0, 0, 0, 1, 8'h06, 8'h06, 0, 0, 0); step("R4 seq invert");
    drive(0, 0, 0, 1, 8'h00, 8'hFF, 0, 0, 0); step("R4 seq clear all");
    drive(1, 8'h01, 8'h00, 1, 8'h01, 8'h01, 0, 0, 0); step("R5 host set then seq invert");
    check("R5 bit0 ends 0", {msg_cc, 8'h00});
    drive(1, 8'h10, 8'h10, 1, 8'h10, 8'h10, 0, 0, 0); step("R5 double invert restores");
    drive(1, 8'h00, 8'h02, 1, 8'h02, 8'h00, 0, 0, 0); step("R5 host clear then seq set");
    drive(1, 8'h03, 8'h00, 1, 8'h03, 8'h00, 1, 2'b11, 2'b00); step("R6 timer overrides last");
    drive(0, 0, 0, 0, 0, 0, 1, 2'b01, 2'b11); step("R6 timer masked write");
    drive(1, 8'hFC, 8'h00, 0, 0, 0, 0, 0, 0); step("R3 setup upper flags");
    drive(0, 0, 0, 0, 0, 0, 1, 2'b11, 2'b00); step("R7 timer leaves flags 2-7");
    check("R7 upper flags still set", {msg_cc, 8'hFC});
    drive(1, 8'h00, 8'h00, 1, 8'h00, 8'h00, 0, 0, 0); step("R8 zero masks hold");
    drive(0, 8'hFF, 8'hFF, 0, 8'hFF, 8'hFF, 0, 2'b11, 2'b11); step("R8 no strobe holds");

    for (int k = 0; k < 3000; k++) begin
      msg_cc = 8'($urandom);
      drive($urandom_range(0, 3) != 0, 8'($urandom), 8'($urandom),
            $urandom_range(0, 3) != 0, 8'($urandom), 8'($urandom),
            $urandom_range(0, 2) != 0, 2'($urandom), 2'($urandom));
      step("R2/R3/R4/R5/R6/R7/R8 random");
    end

    rst_n = 1'b0; #1;
    exp_gp = '0;
    check("R1 reset mid-run", {msg_cc, 8'h00});
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule